// File: doc/BRIEF.md
# Ping-pong DMA channel

A single DMA channel that moves data, one unit per peripheral request, between a fixed peripheral address and a memory buffer. Two buffer descriptors, each a start address and a transfer count, are used in alternation. While one drains, software refills the other. Each buffer has an enable bit and a done bit in a 32-bit mode register. Writing the mode register at one offset sets the bits given as 1, and writing it at another offset clears them. So software never needs a read-modify-write.

A transfer unit is one read from the source address followed by one write to the destination address, over a single-beat request/acknowledge master. When the active buffer's count is zero, the channel retires that buffer: it clears the enable bit and sets the done bit. It moves to the other buffer when that buffer is enabled. Clearing the run bit stops the channel once the unit in flight has finished, and a halted status bit reports this. Counts are in device-width units, and a residue output gives the remaining byte count of the active buffer.

Top module: `pingpong_dma`

## Requirements
- R1: The mode register reads back at byte offsets 0x00 and 0x04. A write to 0x00 sets every writable bit that is 1 in the data. A write to 0x04 clears every writable bit that is 1 in the data. Bits 14 and 31:24 always read 0, and offset 0x1C reads 0.
- R2: Mode bit map. Bit 0 is the buffer 0 enable and bit 1 the buffer 0 done. Bit 2 is the buffer 1 enable and bit 3 the buffer 1 done. Bit 4 is the active buffer (0 = buffer 0), bit 5 is run and bit 6 is halted. Bit 7 is the interrupt enable and bit 8 is non-coherent. Bits 10:9 are the device width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit). Bit 11 is the byte-size transfer flag, bit 12 the direction and bit 13 the endian flag. Bit 15 is the bank select, bits 19:16 the device number and bits 23:20 the peripheral address high bits. Bits 4 and 6 ignore software writes.
- R3: The peripheral address is at 0x08. Buffer 0 has its start at 0x0C and its count at 0x10, and buffer 1 has its start at 0x14 and its count at 0x18. A count register holds the count in bits 15:0 and the buffer address high bits in 19:16, and its other bits read 0. Accesses whose byte offset bits 1:0 are not zero are ignored.
- R4: While run is 1, the active buffer is enabled, its count is non-zero and `per_req_i` is high, the channel performs one unit. It reads the source and then writes the destination. With direction 0 the source is the buffer address {count[19:16], start} and the destination is the peripheral address {mode[23:20], peripheral address}. With direction 1 the two are swapped. On the write acknowledge, `per_ack_o` pulses, the count drops by 1 and the start address advances by 1, 2 or 4 for width codes 0, 1 and 2 (code 3 advances by 1).
- R5: When the active buffer is enabled with count 0 and run is 1 in an idle cycle, the channel clears its enable bit and sets its done bit. Software cannot set a done bit. A done bit clears only when software writes a 1 to its position at 0x04.
- R6: In an idle cycle where the active buffer is not enabled and the other buffer is, the active bit toggles. It never changes while a unit is in flight.
- R7: `irq_o` is high exactly while the interrupt enable bit is 1 and at least one done bit is 1.
- R8: `resid_bytes_o` equals the active buffer's count shifted left by 1 for width code 1, by 2 for width code 2, and not shifted otherwise.
- R9: After run is cleared, a unit already in flight completes and no new unit starts. The halted bit reads 1 from the cycle after the engine is idle with run at 0, and reads 0 otherwise.
- R10: After reset, every register reads 0 except the halted bit (the mode register reads 0x40), `mem_req_o` is low and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| per_req_i | input | 1 | Peripheral requests one unit |
| per_ack_o | output | 1 | One unit finished |
| mem_req_o | output | 1 | Master request |
| mem_we_o | output | 1 | Master write (1) or read (0) |
| mem_addr_o | output | 36 | Master address |
| mem_wdata_o | output | 32 | Master write data |
| mem_rdata_i | input | 32 | Master read data |
| mem_ack_i | input | 1 | Master acknowledge |
| irq_o | output | 1 | Completion interrupt |
| resid_bytes_o | output | 18 | Remaining bytes in the active buffer |

## Verification
The hardest state to reach is a run-bit clear that lands while a unit is already between its read and its write. In that case the count must still drop and the halted bit must wait for the write acknowledge. The stimulus gets there by counting unit acknowledges with the peripheral request held high. It clears run on the second falling edge after the second acknowledge, which is the cycle in which a third unit has just been launched. A zero-count buffer that is enabled while the other buffer is disabled is also used. It forces a toggle and then an immediate retirement, with no peripheral request at all.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  localparam int REG_W = 32;

  localparam int B_EN0  = 0;
  localparam int B_DN0  = 1;
  localparam int B_EN1  = 2;
  localparam int B_DN1  = 3;
  localparam int B_ACT  = 4;
  localparam int B_RUN  = 5;
  localparam int B_HLT  = 6;
  localparam int B_IE   = 7;
  localparam int B_WID  = 9;
  localparam int B_DIR  = 12;
  localparam int B_PAH  = 20;

  localparam logic [REG_W-1:0] SW_MASK   = 32'h00FF_BFA5;
  localparam logic [REG_W-1:0] DONE_MASK = 32'h0000_000A;
  localparam logic [REG_W-1:0] MODE_RST  = 32'h0000_0040;

  localparam logic [2:0] W_MODE_SET = 3'd0;
  localparam logic [2:0] W_MODE_CLR = 3'd1;
  localparam logic [2:0] W_PER      = 3'd2;
  localparam logic [2:0] W_START0   = 3'd3;
  localparam logic [2:0] W_CNT0     = 3'd4;
  localparam logic [2:0] W_START1   = 3'd5;
  localparam logic [2:0] W_CNT1     = 3'd6;

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR} phase_e;

  function automatic logic [2:0] width_step(input logic [1:0] wid);
    case (wid)
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dbdma_mode_reg.sv
module dbdma_mode_reg
  import dbdma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             fin_i,
  input  logic             swap_i,
  input  logic             idle_i,
  output logic [REG_W-1:0] mode_o
);
  logic [REG_W-1:0] mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (set_we_i) mode_d = mode_d | (wdata_i & SW_MASK);
    if (clr_we_i) mode_d = mode_d & ~(wdata_i & (SW_MASK | DONE_MASK));
    // hardware retirement overrides a same-cycle software write
    if (fin_i) begin
      if (mode_q[B_ACT]) begin
        mode_d[B_EN1] = 1'b0;
        mode_d[B_DN1] = 1'b1;
      end else begin
        mode_d[B_EN0] = 1'b0;
        mode_d[B_DN0] = 1'b1;
      end
    end
    if (swap_i) mode_d[B_ACT] = ~mode_q[B_ACT];
    mode_d[B_HLT] = idle_i & ~mode_q[B_RUN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RST;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/dbdma_buf_desc.sv
module dbdma_buf_desc #(
  parameter int REG_W = 32,
  parameter int CNT_W = 16,
  parameter int HI_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_we_i,
  input  logic                  cnt_we_i,
  input  logic [REG_W-1:0]      start_wdata_i,
  input  logic [CNT_W+HI_W-1:0] cnt_wdata_i,
  input  logic                  adv_i,
  input  logic [2:0]            step_i,
  output logic [REG_W-1:0]      start_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [HI_W-1:0]       hi_o
);
  logic [REG_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  hi_q;

  // software writes win over a same-cycle advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cnt_q   <= '0;
      hi_q    <= '0;
    end else begin
      if (start_we_i)  start_q <= start_wdata_i;
      else if (adv_i)  start_q <= start_q + REG_W'(step_i);
      if (cnt_we_i) begin
        cnt_q <= cnt_wdata_i[CNT_W-1:0];
        hi_q  <= cnt_wdata_i[CNT_W+HI_W-1:CNT_W];
      end else if (adv_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign start_o = start_q;
  assign cnt_o   = cnt_q;
  assign hi_o    = hi_q;
endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
  import dbdma_pkg::*;
#(
  parameter int AW = 36,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          act_en_i,
  input  logic          oth_en_i,
  input  logic          cnt_zero_i,
  input  logic          per_req_i,
  input  logic          dir_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [AW-1:0] per_addr_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          unit_done_o,
  output logic          fin_o,
  output logic          swap_o,
  output logic          idle_o
);
  phase_e        ph_q, ph_d;
  logic [DW-1:0] data_q;
  logic          go;
  logic [AW-1:0] src, dst;

  assign idle_o = (ph_q == PH_IDLE);
  assign fin_o  = idle_o & run_i & act_en_i & cnt_zero_i;
  assign swap_o = idle_o & ~act_en_i & oth_en_i;
  assign go     = idle_o & run_i & act_en_i & ~cnt_zero_i & per_req_i;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (go) ph_d = PH_RD;
      PH_RD:   if (mem_ack_i) ph_d = PH_WR;
      PH_WR:   if (mem_ack_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      data_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_RD && mem_ack_i) data_q <= mem_rdata_i;
    end
  end

  assign src         = dir_i ? per_addr_i : buf_addr_i;
  assign dst         = dir_i ? buf_addr_i : per_addr_i;
  assign mem_req_o   = (ph_q != PH_IDLE);
  assign mem_we_o    = (ph_q == PH_WR);
  assign mem_addr_o  = (ph_q == PH_RD) ? src : dst;
  assign mem_wdata_o = data_q;
  assign unit_done_o = (ph_q == PH_WR) & mem_ack_i;
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
  import dbdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HI_W  = 4,
  localparam int AW    = REG_W + HI_W,
  localparam int RES_W = CNT_W + 2,
  localparam int CR_W  = CNT_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [4:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             per_req_i,
  output logic             per_ack_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [REG_W-1:0] mem_wdata_o,
  input  logic [REG_W-1:0] mem_rdata_i,
  input  logic             mem_ack_i,
  output logic             irq_o,
  output logic [RES_W-1:0] resid_bytes_o
);
  logic             aligned;
  logic [2:0]       word;
  logic             wr_ok;
  logic [REG_W-1:0] mode_q;
  logic [REG_W-1:0] per_q;
  logic [REG_W-1:0] start_a [2];
  logic [CNT_W-1:0] cnt_a [2];
  logic [HI_W-1:0]  hi_a [2];
  logic             act;
  logic [CNT_W-1:0] act_cnt;
  logic [AW-1:0]    buf_addr, per_addr;
  logic             unit_done, fin, swap, idle;
  logic [2:0]       step;

  assign aligned = (reg_addr_i[1:0] == 2'b00);
  assign word    = reg_addr_i[4:2];
  assign wr_ok   = reg_wr_i & aligned;

  dbdma_mode_reg u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (wr_ok && word == W_MODE_SET),
    .clr_we_i (wr_ok && word == W_MODE_CLR),
    .wdata_i  (reg_wdata_i),
    .fin_i    (fin),
    .swap_i   (swap),
    .idle_i   (idle),
    .mode_o   (mode_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    per_q <= '0;
    else if (wr_ok && word == W_PER) per_q <= reg_wdata_i;
  end

  assign act  = mode_q[B_ACT];
  assign step = width_step(mode_q[B_WID+1:B_WID]);

  for (genvar b = 0; b < 2; b++) begin : g_desc
    localparam logic [2:0] WS = (b == 0) ? W_START0 : W_START1;
    localparam logic [2:0] WC = (b == 0) ? W_CNT0 : W_CNT1;
    dbdma_buf_desc #(.REG_W(REG_W), .CNT_W(CNT_W), .HI_W(HI_W)) u_desc (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .start_we_i    (wr_ok && word == WS),
      .cnt_we_i      (wr_ok && word == WC),
      .start_wdata_i (reg_wdata_i),
      .cnt_wdata_i   (reg_wdata_i[CR_W-1:0]),
      .adv_i         (unit_done && (act == 1'(b))),
      .step_i        (step),
      .start_o       (start_a[b]),
      .cnt_o         (cnt_a[b]),
      .hi_o          (hi_a[b])
    );
  end

  assign act_cnt  = act ? cnt_a[1] : cnt_a[0];
  assign buf_addr = act ? {hi_a[1], start_a[1]} : {hi_a[0], start_a[0]};
  assign per_addr = {mode_q[B_PAH+HI_W-1:B_PAH], per_q};

  dbdma_engine #(.AW(AW), .DW(REG_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (mode_q[B_RUN]),
    .act_en_i    (act ? mode_q[B_EN1] : mode_q[B_EN0]),
    .oth_en_i    (act ? mode_q[B_EN0] : mode_q[B_EN1]),
    .cnt_zero_i  (act_cnt == '0),
    .per_req_i   (per_req_i),
    .dir_i       (mode_q[B_DIR]),
    .buf_addr_i  (buf_addr),
    .per_addr_i  (per_addr),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .unit_done_o (unit_done),
    .fin_o       (fin),
    .swap_o      (swap),
    .idle_o      (idle)
  );

  assign per_ack_o = unit_done;
  assign irq_o     = mode_q[B_IE] & (mode_q[B_DN0] | mode_q[B_DN1]);

  always_comb begin
    case (mode_q[B_WID+1:B_WID])
      2'd1:    resid_bytes_o = RES_W'(act_cnt) << 1;
      2'd2:    resid_bytes_o = RES_W'(act_cnt) << 2;
      default: resid_bytes_o = RES_W'(act_cnt);
    endcase
  end

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      case (word)
        W_MODE_SET, W_MODE_CLR: reg_rdata_o = mode_q;
        W_PER:    reg_rdata_o = per_q;
        W_START0: reg_rdata_o = start_a[0];
        W_CNT0:   reg_rdata_o = REG_W'({hi_a[0], cnt_a[0]});
        W_START1: reg_rdata_o = start_a[1];
        W_CNT1:   reg_rdata_o = REG_W'({hi_a[1], cnt_a[1]});
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_dma_chk.sv
module pingpong_dma_chk #(
  parameter int CNT_W = 16,
  parameter int AW    = 36
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [4:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             mem_ack_i,
  input logic [AW-1:0]    mem_addr_o,
  input logic             per_ack_o,
  input logic [31:0]      mode_i,
  input logic [CNT_W-1:0] act_cnt_i
);
  logic cnt_wr, clr_wr;
  assign cnt_wr = reg_wr_i && (reg_addr_i == 5'h10 || reg_addr_i == 5'h18);
  assign clr_wr = reg_wr_i && (reg_addr_i == 5'h04);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_wr_after_rd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !$past(mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

  assert_cnt_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o && !cnt_wr |=> act_cnt_i == $past(act_cnt_i) - CNT_W'(1));

  assert_done0_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] && !(clr_wr && reg_wdata_i[1]) |=> mode_i[1]);

  assert_done1_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[3] && !(clr_wr && reg_wdata_i[3]) |=> mode_i[3]);

  assert_act_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[4] != $past(mode_i[4]) |-> !$past(mem_req_o));

  assert_halt_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[6] |-> !mem_req_o);
endmodule

bind pingpong_dma pingpong_dma_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .per_ack_o   (per_ack_o),
  .mode_i      (mode_q),
  .act_cnt_i   (act_cnt)
);

// File: tb/pingpong_dma_test.sv
module pingpong_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic        mem_req, mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        irq;
  logic [17:0] resid;

  int checks = 0;
  int fails = 0;
  int acks = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pingpong_dma uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .per_req_i(per_req), .per_ack_o(per_ack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .irq_o(irq), .resid_bytes_o(resid)
  );

  // memory responder: acknowledges every other cycle of a request
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= {mem_addr[15:0] ^ 16'h5A5A, mem_addr[31:16]};
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] m_mode;
  logic [31:0] m_per;
  logic [31:0] m_start [2];
  logic [15:0] m_cnt [2];
  logic [3:0]  m_hi [2];
  int          m_ph;
  logic [31:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 32'h40; m_per = 0; m_ph = 0; m_data = 0;
      for (int i = 0; i < 2; i++) begin m_start[i] = 0; m_cnt[i] = 0; m_hi[i] = 0; end
    end else begin
      automatic int a = m_mode[4];
      automatic bit en_a = a ? m_mode[2] : m_mode[0];
      automatic bit en_o = a ? m_mode[0] : m_mode[2];
      automatic bit run = m_mode[5];
      automatic bit idle = (m_ph == 0);
      automatic bit go = idle && run && en_a && m_cnt[a] != 0 && per_req;
      automatic bit fin = idle && run && en_a && m_cnt[a] == 0;
      automatic bit swp = idle && !en_a && en_o;
      automatic bit ud = (m_ph == 2) && mem_ack;
      automatic int stp = (m_mode[10:9] == 1) ? 2 : (m_mode[10:9] == 2) ? 4 : 1;
      automatic logic [31:0] nm = m_mode;
      automatic bit wok = reg_wr && reg_addr[1:0] == 0;
      if (wok && reg_addr == 5'h00) nm = nm | (reg_wdata & 32'h00FFBFA5);
      if (wok && reg_addr == 5'h04) nm = nm & ~(reg_wdata & 32'h00FFBFAF);
      if (fin) begin nm[a*2] = 0; nm[a*2+1] = 1; end
      if (swp) nm[4] = ~m_mode[4];
      nm[6] = idle && !run;
      if (ud) begin m_cnt[a] = m_cnt[a] - 1; m_start[a] = m_start[a] + stp; end
      if (m_ph == 1 && mem_ack) m_data = mem_rdata;
      if (wok) begin
        case (reg_addr)
          5'h08: m_per = reg_wdata;
          5'h0C: m_start[0] = reg_wdata;
          5'h10: begin m_cnt[0] = reg_wdata[15:0]; m_hi[0] = reg_wdata[19:16]; end
          5'h14: m_start[1] = reg_wdata;
          5'h18: begin m_cnt[1] = reg_wdata[15:0]; m_hi[1] = reg_wdata[19:16]; end
          default: ;
        endcase
      end
      if (m_ph == 0 && go) m_ph = 1;
      else if (m_ph == 1 && mem_ack) m_ph = 2;
      else if (m_ph == 2 && mem_ack) m_ph = 0;
      m_mode = nm;
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] ad);
    if (ad[1:0] != 0) return 0;
    case (ad)
      5'h00, 5'h04: return m_mode;
      5'h08: return m_per;
      5'h0C: return m_start[0];
      5'h10: return {12'h0, m_hi[0], m_cnt[0]};
      5'h14: return m_start[1];
      5'h18: return {12'h0, m_hi[1], m_cnt[1]};
      default: return 0;
    endcase
  endfunction

  task automatic fail_line(input string req, input logic [63:0] got, input logic [63:0] exp);
    fails++;
    $display("FAIL %s cycle %0d: got %0h expected %0h", req, cyc, got, exp);
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !finished) begin
      automatic int a = m_mode[4];
      automatic logic [35:0] ba = {m_hi[a], m_start[a]};
      automatic logic [35:0] pa = {m_mode[23:20], m_per};
      automatic logic [35:0] ea = (m_ph == 1) ? (m_mode[12] ? pa : ba) : (m_mode[12] ? ba : pa);
      automatic int sh = (m_mode[10:9] == 1) ? 1 : (m_mode[10:9] == 2) ? 2 : 0;
      automatic logic [17:0] er = 18'(m_cnt[a]) << sh;
      automatic bit ei = m_mode[7] && (m_mode[1] || m_mode[3]);
      automatic bit eack = (m_ph == 2) && mem_ack;
      automatic int f0 = fails;
      cyc++;
      checks++;
      if (mem_req !== (m_ph != 0)) fail_line("R4 mem_req", mem_req, m_ph != 0);
      if (m_ph != 0) begin
        if (mem_we !== (m_ph == 2)) fail_line("R4 mem_we", mem_we, m_ph == 2);
        if (mem_addr !== ea) fail_line("R4 mem_addr", mem_addr, ea);
        if (m_ph == 2 && mem_wdata !== m_data) fail_line("R4 mem_wdata", mem_wdata, m_data);
      end
      if (per_ack !== eack) fail_line("R4 per_ack", per_ack, eack);
      if (irq !== ei) fail_line("R7 irq", irq, ei);
      if (resid !== er) fail_line("R8 resid", resid, er);
      if (reg_rdata !== m_read(reg_addr)) fail_line("R1 reg_rdata", reg_rdata, m_read(reg_addr));
      if (fails != f0) ; // already reported
      if (per_ack) acks++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [4:0] ad, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = ad;
    #1;
    checks++;
    if (reg_rdata !== exp) fail_line(req, reg_rdata, exp);
  endtask

  task automatic chk_val(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) fail_line(req, got, exp);
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R10 reset state
    chk_reg("R10 mode after reset", 5'h00, 32'h40);
    chk_reg("R1 mode at clear offset", 5'h04, 32'h40);
    chk_reg("R10 count0 after reset", 5'h10, 32'h0);
    chk_val("R10 irq after reset", {31'b0, irq}, 0);
    chk_reg("R1 unused offset", 5'h1C, 32'h0);

    // ping-pong run, 32-bit width, memory to peripheral
    wr(5'h08, 32'h1000_0000);
    wr(5'h0C, 32'h0000_0100);
    wr(5'h10, 32'hFFF3_0003);
    wr(5'h14, 32'h0000_0200);
    wr(5'h18, 32'h0000_0002);
    chk_reg("R3 count layout", 5'h10, 32'h0003_0003);
    wr(5'h00, 32'h0050_04A5);
    per_req = 1'b1;
    tick(60);
    chk_reg("R5 R6 both buffers retired", 5'h00, 32'h0050_04BA);
    chk_reg("R4 start0 advanced by 4", 5'h0C, 32'h0000_010C);
    chk_reg("R4 start1 advanced by 4", 5'h14, 32'h0000_0208);
    chk_val("R4 unit count", acks, 5);
    chk_val("R7 irq with done", {31'b0, irq}, 1);

    // done bits: no software set, clear only by 0x04
    wr(5'h04, 32'h0000_0002);
    wr(5'h00, 32'h0000_000A);
    wr(5'h04, 32'h0000_0050);
    chk_reg("R5 R2 done set ignored, status bits kept", 5'h00, 32'h0050_04B8);
    chk_val("R7 irq held by done1", {31'b0, irq}, 1);
    wr(5'h04, 32'h0000_0008);
    tick(1);
    chk_val("R7 irq off", {31'b0, irq}, 0);

    // halt mid-buffer, 16-bit width, peripheral to memory
    per_req = 1'b0;
    wr(5'h04, 32'h0000_0600);
    wr(5'h00, 32'h0000_1200);
    wr(5'h14, 32'h0000_0300);
    wr(5'h18, 32'h0000_0005);
    acks = 0;
    wr(5'h00, 32'h0000_0004);
    per_req = 1'b1;
    while (acks < 2) @(negedge clk);
    wr(5'h04, 32'h0000_0020);
    tick(20);
    chk_val("R9 in-flight unit completed", acks, 3);
    chk_reg("R9 halted status", 5'h00, 32'h0050_12D4);
    chk_reg("R9 count left", 5'h18, 32'h0000_0002);
    chk_reg("R4 start1 advanced by 2", 5'h14, 32'h0000_0306);
    chk_val("R8 residue 16-bit", {14'b0, resid}, 4);

    // zero-count buffer: toggle then immediate retirement
    per_req = 1'b0;
    wr(5'h04, 32'h0000_0604);
    wr(5'h10, 32'h0000_0000);
    wr(5'h00, 32'h0000_0021);
    tick(6);
    chk_reg("R6 R5 toggle and zero-count retire", 5'h00, 32'h0050_10A2);
    chk_val("R7 irq on done0", {31'b0, irq}, 1);

    // 8-bit width units
    wr(5'h04, 32'h0000_0002);
    wr(5'h0C, 32'h0000_0400);
    wr(5'h10, 32'h0000_0002);
    acks = 0;
    wr(5'h00, 32'h0000_0001);
    per_req = 1'b1;
    tick(30);
    per_req = 1'b0;
    chk_val("R4 two units at 8-bit", acks, 2);
    chk_reg("R4 start0 advanced by 1", 5'h0C, 32'h0000_0402);

    // residue under width codes 3 and 1
    wr(5'h10, 32'h0000_0007);
    wr(5'h00, 32'h0000_0600);
    tick(1);
    chk_val("R8 residue code 3", {14'b0, resid}, 7);
    wr(5'h04, 32'h0000_0400);
    tick(1);
    chk_val("R8 residue code 1", {14'b0, resid}, 14);
    chk_reg("R3 misaligned read", 5'h09, 32'h0);

    tick(3);
    summary();
  end
endmodule